// File: doc/BRIEF.md
# Cipher Unit Error Status Logic

This block watches the host-side register traffic of a single/triple DES cipher engine and records configuration and access mistakes in a 64-bit sticky status register. It snoops key, key-size, data-size, mode and IV register accesses. It also receives the engine's busy flag, its start strobe, a raw internal-error pulse and nine further error pulses from the FIFO and sequencing logic. From these it derives key parity errors, key size errors, context errors (register writes while busy) and early-read errors (IV read while busy).

A host-written mask register gates which status bits may be set. Writing a 1 to a mask bit also clears the matching status bit. While any status bit is set, the block holds the engine in halt and raises the error interrupt. Status bits use big-endian numbering, so bit 0 is the most significant. Only bits 50 to 63 carry errors.

Top module: `cipher_err_status`

## Requirements
- R1: Status bits 0 to 49 and mask bits 0 to 49 always read zero. The error bits sit at these positions: key parity 50, internal 51, early read 52, context 53, key size 54, and `aux_err_pulse[i]` at bit 55+i for i = 0..8.
- R2: A status bit becomes set only if the mask bit at the same position was zero in the cycle of the event.
- R3: `halt_o` is high in every cycle in which any status bit is set. `irq_o` is a register that goes high one cycle after the status first becomes nonzero and low one cycle after the last status bit clears.
- R4: When `eng_start` is high, every byte of key 1 must have odd parity. Key byte j is `key[8j+7:8j]`, and its parity bit is bit 8j. Any byte with even parity sets the key parity bit.
- R5: Key 2 is checked at start only when the mode is triple DES and the key size is 16 or 24. Key 3 is checked only when the mode is triple DES and the key size is 24. The mode and key size used are the values held when `eng_start` is seen.
- R6: A key size write (select 3, value in `wr_data[7:0]`) sets the key size bit unless one of two cases holds: the value is 8 and the held mode is single DES, or the value is 16 or 24 and the held mode is triple DES. The mode is select 5, and `wr_data[0]`=1 means triple DES.
- R7: A read of the IV register (select 6) while `eng_busy` is high sets the early read bit. Reads of other registers, and IV reads while idle, set nothing.
- R8: A write to any of selects 0 to 6 while `eng_busy` is high sets the context bit. Writes while idle do not. Select 7 addresses nothing.
- R9: `int_err_pulse` sets bit 51. Each `aux_err_pulse[i]` sets bit 55+i.
- R10: Status bits are sticky. A mask write with a 1 in a bit clears that status bit, and the mask register takes the written value. An event in the same cycle as its clear leaves the bit set.
- R11: Reset clears the status, the mask and `irq_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Host register write strobe |
| wr_sel | input | 3 | Write target: 0..2 keys 1..3, 3 key size, 4 data size, 5 mode, 6 IV, 7 none |
| wr_data | input | 64 | Write data |
| rd_en | input | 1 | Host register read strobe |
| rd_sel | input | 3 | Read target, same encoding as `wr_sel` |
| mask_wr_en | input | 1 | Mask register write strobe |
| mask_wr_data | input | 64 | New mask value, big-endian bit order |
| eng_busy | input | 1 | Engine is processing |
| eng_start | input | 1 | Engine start strobe, triggers key parity check |
| int_err_pulse | input | 1 | Raw internal error |
| aux_err_pulse | input | 9 | Data size, mode, address, output FIFO, input FIFO, input underflow, input overflow, output underflow, output overflow errors |
| status_o | output | 64 | Status register, big-endian bit order |
| mask_o | output | 64 | Mask register, big-endian bit order |
| halt_o | output | 1 | Halt request to the engine |
| irq_o | output | 1 | Registered error interrupt |

## Verification
The hardest cases to reach are the ones where several conditions meet in a single cycle. One is a clear that lands together with a new event on the same bit. Another is a start whose parity outcome depends on the mode and key size programmed earlier. A third is a key size write judged against the mode written before it. The stimulus builds each case in sequence. It programs mode and key size first. It then loads deliberately bad keys into registers 2 and 3 and starts the engine under each key size, so that unused bad keys are shown to be ignored. Finally it fires an event in the same cycle as the mask write that clears it. A behavioural model tracks the status, mask, halt and interrupt every cycle alongside these directed checks.

// File: rtl/cues_pkg.sv
package cues_pkg;
    localparam int STAT_W   = 64;
    localparam int KEY_W    = 64;
    localparam int BYTE_W   = 8;
    localparam int KS_W     = 8;
    localparam int NKEYS    = 3;
    localparam int N_AUX    = 9;
    localparam int B_KPE    = 50;
    localparam int B_IE     = 51;
    localparam int B_ERE    = 52;
    localparam int B_CE     = 53;
    localparam int B_KSE    = 54;
    localparam int B_AUX    = 55;
    localparam int KS_ONE   = 8;
    localparam int KS_TWO   = 16;
    localparam int KS_THREE = 24;

    typedef enum logic [2:0] {
        SEL_KEY1  = 3'd0,
        SEL_KEY2  = 3'd1,
        SEL_KEY3  = 3'd2,
        SEL_KSIZE = 3'd3,
        SEL_DSIZE = 3'd4,
        SEL_MODE  = 3'd5,
        SEL_IV    = 3'd6,
        SEL_NONE  = 3'd7
    } reg_sel_e;

    typedef struct packed {
        logic [KEY_W-1:0] key1;
        logic [KEY_W-1:0] key2;
        logic [KEY_W-1:0] key3;
        logic [KS_W-1:0]  ksize;
        logic             tdes;
    } cfg_t;

    typedef struct packed {
        logic [0:STAT_W-1] stat;
        logic [0:STAT_W-1] mask;
        logic              irq;
    } st_t;
endpackage

// File: rtl/cues_cfg.sv
module cues_cfg
    import cues_pkg::*;
#(
    parameter int DATA_W   = 64,
    parameter int TDES_BIT = 0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [2:0]        wr_sel,
    input  logic [DATA_W-1:0] wr_data,
    output cfg_t              cfg_o
);
    cfg_t cfg_d, cfg_q;

    always_comb begin
        cfg_d = cfg_q;
        if (wr_en) begin
            case (reg_sel_e'(wr_sel))
                SEL_KEY1:  cfg_d.key1  = wr_data[KEY_W-1:0];
                SEL_KEY2:  cfg_d.key2  = wr_data[KEY_W-1:0];
                SEL_KEY3:  cfg_d.key3  = wr_data[KEY_W-1:0];
                SEL_KSIZE: cfg_d.ksize = wr_data[KS_W-1:0];
                SEL_MODE:  cfg_d.tdes  = wr_data[TDES_BIT];
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cfg_q <= '0;
        else        cfg_q <= cfg_d;
    end

    assign cfg_o = cfg_q;
endmodule

// File: rtl/cues_keyparity.sv
module cues_keyparity
    import cues_pkg::*;
(
    input  cfg_t cfg,
    input  logic start,
    output logic kpe_evt
);
    localparam int NBYTES = KEY_W / BYTE_W;

    logic [KEY_W-1:0] keys [NKEYS];
    logic [NKEYS-1:0] bad;
    logic [NKEYS-1:0] used;

    assign keys[0] = cfg.key1;
    assign keys[1] = cfg.key2;
    assign keys[2] = cfg.key3;

    for (genvar k = 0; k < NKEYS; k++) begin : g_key
        logic [NBYTES-1:0] byte_even;
        for (genvar b = 0; b < NBYTES; b++) begin : g_byte
            assign byte_even[b] = ~(^keys[k][b*BYTE_W +: BYTE_W]);
        end
        assign bad[k] = |byte_even;
    end

    assign used[0] = 1'b1;
    assign used[1] = cfg.tdes && (cfg.ksize == KS_W'(KS_TWO) || cfg.ksize == KS_W'(KS_THREE));
    assign used[2] = cfg.tdes && (cfg.ksize == KS_W'(KS_THREE));

    assign kpe_evt = start && |(bad & used);
endmodule

// File: rtl/cues_detect.sv
module cues_detect
    import cues_pkg::*;
#(
    parameter int DATA_W = 64
) (
    input  logic              wr_en,
    input  logic [2:0]        wr_sel,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rd_en,
    input  logic [2:0]        rd_sel,
    input  logic              busy,
    input  logic              tdes,
    output logic              ce_evt,
    output logic              ere_evt,
    output logic              kse_evt
);
    logic [KS_W-1:0] ks_val;
    logic            ks_ok;

    assign ks_val = wr_data[KS_W-1:0];

    always_comb begin
        ks_ok   = (ks_val == KS_W'(KS_ONE) && !tdes)
               || ((ks_val == KS_W'(KS_TWO) || ks_val == KS_W'(KS_THREE)) && tdes);
        ce_evt  = wr_en && busy && (reg_sel_e'(wr_sel) != SEL_NONE);
        ere_evt = rd_en && busy && (reg_sel_e'(rd_sel) == SEL_IV);
        kse_evt = wr_en && (reg_sel_e'(wr_sel) == SEL_KSIZE) && !ks_ok;
    end
endmodule

// File: rtl/cues_statreg.sv
module cues_statreg
    import cues_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [0:STAT_W-1] evt,
    input  logic              mask_wr_en,
    input  logic [0:STAT_W-1] mask_wr_data,
    output logic [0:STAT_W-1] stat_o,
    output logic [0:STAT_W-1] mask_o,
    output logic              irq_o
);
    localparam logic [0:STAT_W-1] VALID = {{B_KPE{1'b0}}, {(STAT_W-B_KPE){1'b1}}};

    st_t               st_d, st_q;
    logic [0:STAT_W-1] clr;
    logic [0:STAT_W-1] set;

    always_comb begin
        clr       = mask_wr_en ? (mask_wr_data & VALID) : '0;
        set       = evt & ~st_q.mask & VALID;
        st_d      = st_q;
        st_d.stat = (st_q.stat & ~clr) | set;
        st_d.mask = mask_wr_en ? (mask_wr_data & VALID) : st_q.mask;
        st_d.irq  = |st_q.stat;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign stat_o = st_q.stat;
    assign mask_o = st_q.mask;
    assign irq_o  = st_q.irq;

    assert_no_set_when_masked_R2: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((st_q.stat & ~$past(st_q.stat) & $past(st_q.mask)) == '0));

    assert_sticky_until_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (($past(st_q.stat) & ~$past(clr) & ~st_q.stat) == '0));

    assert_event_beats_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (($past(evt) & ~$past(st_q.mask) & $past(VALID) & ~st_q.stat) == '0));
endmodule

// File: rtl/cipher_err_status.sv
module cipher_err_status
    import cues_pkg::*;
#(
    parameter int DATA_W   = 64,
    parameter int TDES_BIT = 0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [2:0]        wr_sel,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rd_en,
    input  logic [2:0]        rd_sel,
    input  logic              mask_wr_en,
    input  logic [0:63]       mask_wr_data,
    input  logic              eng_busy,
    input  logic              eng_start,
    input  logic              int_err_pulse,
    input  logic [0:8]        aux_err_pulse,
    output logic [0:63]       status_o,
    output logic [0:63]       mask_o,
    output logic              halt_o,
    output logic              irq_o
);
    cfg_t              cfg;
    logic              kpe_evt, ce_evt, ere_evt, kse_evt;
    logic [0:STAT_W-1] evt;

    cues_cfg #(.DATA_W(DATA_W), .TDES_BIT(TDES_BIT)) u_cfg (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
        .wr_data(wr_data), .cfg_o(cfg)
    );

    cues_keyparity u_par (.cfg(cfg), .start(eng_start), .kpe_evt(kpe_evt));

    cues_detect #(.DATA_W(DATA_W)) u_det (
        .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data), .rd_en(rd_en),
        .rd_sel(rd_sel), .busy(eng_busy), .tdes(cfg.tdes),
        .ce_evt(ce_evt), .ere_evt(ere_evt), .kse_evt(kse_evt)
    );

    always_comb begin
        evt        = '0;
        evt[B_KPE] = kpe_evt;
        evt[B_IE]  = int_err_pulse;
        evt[B_ERE] = ere_evt;
        evt[B_CE]  = ce_evt;
        evt[B_KSE] = kse_evt;
        for (int i = 0; i < N_AUX; i++) evt[B_AUX+i] = aux_err_pulse[i];
    end

    cues_statreg u_stat (
        .clk(clk), .rst_n(rst_n), .evt(evt), .mask_wr_en(mask_wr_en),
        .mask_wr_data(mask_wr_data), .stat_o(status_o), .mask_o(mask_o),
        .irq_o(irq_o)
    );

    assign halt_o = |status_o;

    assert_halt_then_irq_R3: assert property (@(posedge clk) disable iff (!rst_n)
        halt_o |=> irq_o);

    assert_ctx_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && eng_busy && wr_sel != 3'd7 && !mask_o[B_CE]) |=> status_o[B_CE]);

    assert_early_read_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && eng_busy && rd_sel == 3'd6 && !mask_o[B_ERE]) |=> status_o[B_ERE]);

    assert_bad_ksize_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_sel == 3'd3 && wr_data[7:0] == 8'd12 && !mask_o[B_KSE]) |=> status_o[B_KSE]);

    assert_internal_err_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (int_err_pulse && !mask_o[B_IE]) |=> status_o[B_IE]);
endmodule

// File: tb/cipher_err_status_bench.sv
module cipher_err_status_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0, rd_en = 1'b0, mask_wr_en = 1'b0;
    logic [2:0]  wr_sel = 3'd7, rd_sel = 3'd7;
    logic [63:0] wr_data = '0;
    logic [0:63] mask_wr_data = '0;
    logic        eng_busy = 1'b0, eng_start = 1'b0, int_err_pulse = 1'b0;
    logic [0:8]  aux_err_pulse = '0;
    logic [0:63] status_o, mask_o;
    logic        halt_o, irq_o;

    int errors = 0;
    int checks = 0;
    int cycles = 0;

    always #5 clk = ~clk;

    cipher_err_status u_cipher_err_status (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
        .rd_en(rd_en), .rd_sel(rd_sel), .mask_wr_en(mask_wr_en), .mask_wr_data(mask_wr_data),
        .eng_busy(eng_busy), .eng_start(eng_start), .int_err_pulse(int_err_pulse),
        .aux_err_pulse(aux_err_pulse), .status_o(status_o), .mask_o(mask_o),
        .halt_o(halt_o), .irq_o(irq_o)
    );

    // Behavioural reference model
    logic [0:63] m_stat, m_mask;
    logic        m_irq, m_tdes;
    logic [63:0] m_key [3];
    int          m_ks;

    function automatic bit key_ok(logic [63:0] k);
        for (int j = 0; j < 8; j++) if ((^k[8*j +: 8]) == 1'b0) return 1'b0;
        return 1'b1;
    endfunction

    always @(posedge clk) begin
        logic [0:63] ev, cl;
        if (!rst_n) begin
            m_stat = '0; m_mask = '0; m_irq = 1'b0; m_tdes = 1'b0; m_ks = 0;
            m_key[0] = '0; m_key[1] = '0; m_key[2] = '0;
        end else begin
            ev = '0;
            if (eng_start) begin
                if (!key_ok(m_key[0])) ev[50] = 1'b1;
                if (m_tdes && (m_ks == 16 || m_ks == 24) && !key_ok(m_key[1])) ev[50] = 1'b1;
                if (m_tdes && m_ks == 24 && !key_ok(m_key[2])) ev[50] = 1'b1;
            end
            ev[51] = int_err_pulse;
            if (rd_en && eng_busy && rd_sel == 3'd6) ev[52] = 1'b1;
            if (wr_en && eng_busy && wr_sel != 3'd7) ev[53] = 1'b1;
            if (wr_en && wr_sel == 3'd3) begin
                if (!((wr_data[7:0] == 8 && !m_tdes) ||
                      ((wr_data[7:0] == 16 || wr_data[7:0] == 24) && m_tdes))) ev[54] = 1'b1;
            end
            for (int i = 0; i < 9; i++) ev[55+i] = aux_err_pulse[i];
            for (int i = 0; i < 50; i++) ev[i] = 1'b0;
            cl = '0;
            if (mask_wr_en) for (int i = 50; i < 64; i++) cl[i] = mask_wr_data[i];
            m_irq  = (m_stat != '0);
            m_stat = (m_stat & ~cl) | (ev & ~m_mask);
            if (mask_wr_en) m_mask = cl;
            if (wr_en) begin
                case (wr_sel)
                    3'd0: m_key[0] = wr_data;
                    3'd1: m_key[1] = wr_data;
                    3'd2: m_key[2] = wr_data;
                    3'd3: m_ks = int'(wr_data[7:0]);
                    3'd5: m_tdes = wr_data[0];
                    default: ;
                endcase
            end
        end
    end

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Advance one clock, compare against the model, release pulse inputs
    task automatic tick();
        @(negedge clk);
        if (rst_n) begin
            chk(status_o === m_stat, "R1 status vs model", status_o, m_stat);
            chk(mask_o === m_mask, "R10 mask vs model", mask_o, m_mask);
            chk(halt_o === (m_stat != '0), "R3 halt vs model", 64'(halt_o), 64'(m_stat != '0));
            chk(irq_o === m_irq, "R3 irq vs model", 64'(irq_o), 64'(m_irq));
        end
        wr_en = 1'b0; rd_en = 1'b0; mask_wr_en = 1'b0; eng_start = 1'b0;
        int_err_pulse = 1'b0; aux_err_pulse = '0; wr_sel = 3'd7; rd_sel = 3'd7;
    endtask

    task automatic wr(input logic [2:0] s, input logic [63:0] d);
        wr_en = 1'b1; wr_sel = s; wr_data = d; tick();
    endtask

    task automatic mwr(input logic [0:63] d);
        mask_wr_en = 1'b1; mask_wr_data = d; tick();
    endtask

    task automatic clear_all();
        logic [0:63] all1 = '1;
        mwr(all1); mwr('0); tick();
    endtask

    function automatic logic [0:63] onebit(input int b);
        logic [0:63] v = '0;
        v[b] = 1'b1;
        return v;
    endfunction

    localparam logic [63:0] GOOD = 64'h0101010101010101;
    localparam logic [63:0] BAD  = 64'h0101010101010100;

    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 20000) begin
                errors++; checks++;
                $display("FAIL watchdog expired");
                $display("Result: errors=%0d of %0d checks", errors, checks);
                $finish;
            end
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R11: reset state
        chk(status_o === '0 && mask_o === '0 && irq_o === 1'b0 && halt_o === 1'b0,
            "R11 reset state", status_o, '0);
        rst_n = 1'b1;
        tick();

        // R4: key 1 parity
        wr(3'd3, 64'd8);
        wr(3'd0, GOOD);
        eng_start = 1'b1; tick();
        chk(status_o[50] === 1'b0, "R4 good key1 no error", 64'(status_o[50]), 64'd0);
        wr(3'd0, BAD);
        eng_start = 1'b1; tick();
        chk(status_o[50] === 1'b1, "R4 bad key1 sets bit 50", 64'(status_o[50]), 64'd1);
        chk(halt_o === 1'b1 && irq_o === 1'b0, "R3 halt now, irq next", {halt_o, irq_o}, 64'b10);
        tick();
        chk(irq_o === 1'b1, "R3 irq one cycle later", 64'(irq_o), 64'd1);
        clear_all();
        chk(status_o === '0 && irq_o === 1'b0, "R3 irq low after clear", {status_o[50], irq_o}, 64'd0);
        wr(3'd0, GOOD);

        // R5: key 2/3 used only in triple mode with matching size
        wr(3'd1, BAD); wr(3'd2, BAD);
        eng_start = 1'b1; tick();
        chk(status_o[50] === 1'b0, "R5 single mode ignores key2/3", 64'(status_o[50]), 64'd0);
        wr(3'd5, 64'd1); wr(3'd3, 64'd16);
        chk(status_o[54] === 1'b0, "R6 ksize 16 valid in triple", 64'(status_o[54]), 64'd0);
        eng_start = 1'b1; tick();
        chk(status_o[50] === 1'b1, "R5 size 16 checks key2", 64'(status_o[50]), 64'd1);
        clear_all();
        wr(3'd1, GOOD);
        eng_start = 1'b1; tick();
        chk(status_o[50] === 1'b0, "R5 size 16 ignores key3", 64'(status_o[50]), 64'd0);
        wr(3'd3, 64'd24);
        eng_start = 1'b1; tick();
        chk(status_o[50] === 1'b1, "R5 size 24 checks key3", 64'(status_o[50]), 64'd1);
        clear_all();
        wr(3'd2, GOOD);

        // R6: key size legality
        wr(3'd3, 64'd12);
        chk(status_o[54] === 1'b1, "R6 ksize 12 invalid", 64'(status_o[54]), 64'd1);
        clear_all();
        wr(3'd3, 64'd8);
        chk(status_o[54] === 1'b1, "R6 ksize 8 invalid in triple", 64'(status_o[54]), 64'd1);
        clear_all();
        wr(3'd5, 64'd0); wr(3'd3, 64'd16);
        chk(status_o[54] === 1'b1, "R6 ksize 16 invalid in single", 64'(status_o[54]), 64'd1);
        clear_all();
        wr(3'd3, 64'd8);
        chk(status_o[54] === 1'b0, "R6 ksize 8 valid in single", 64'(status_o[54]), 64'd0);

        // R7 / R8: busy accesses
        eng_busy = 1'b1;
        rd_en = 1'b1; rd_sel = 3'd0; tick();
        chk(status_o === '0, "R7 key read while busy ignored", status_o, '0);
        rd_en = 1'b1; rd_sel = 3'd6; tick();
        chk(status_o[52] === 1'b1, "R7 IV read while busy", 64'(status_o[52]), 64'd1);
        wr(3'd7, 64'd5);
        chk(status_o[53] === 1'b0, "R8 select 7 not a register", 64'(status_o[53]), 64'd0);
        wr(3'd4, 64'd5);
        chk(status_o[53] === 1'b1, "R8 write while busy", 64'(status_o[53]), 64'd1);
        eng_busy = 1'b0;
        clear_all();
        rd_en = 1'b1; rd_sel = 3'd6; tick();
        wr(3'd6, 64'd3);
        chk(status_o === '0, "R7 R8 idle accesses ignored", status_o, '0);

        // R9: internal and auxiliary pulses
        int_err_pulse = 1'b1; tick();
        chk(status_o[51] === 1'b1, "R9 internal error bit 51", 64'(status_o[51]), 64'd1);
        clear_all();
        for (int i = 0; i < 9; i++) begin
            aux_err_pulse = '0; aux_err_pulse[i] = 1'b1; tick();
            chk(status_o === onebit(55+i), "R9 aux pulse position", status_o, onebit(55+i));
            clear_all();
        end

        // R2: masked bit cannot set; R1 reserved mask bits read zero
        mwr('1);
        chk(mask_o[0:49] === '0 && mask_o[50:63] === '1, "R1 mask reserved zero", mask_o, {50'b0, 14'h3fff});
        int_err_pulse = 1'b1; aux_err_pulse = '1; tick();
        chk(status_o === '0, "R2 masked events ignored", status_o, '0);
        mwr(onebit(51));
        aux_err_pulse[0] = 1'b1; int_err_pulse = 1'b1; tick();
        chk(status_o === onebit(55), "R2 only unmasked bit sets", status_o, onebit(55));
        clear_all();

        // R10: event same cycle as clear wins
        int_err_pulse = 1'b1; tick();
        int_err_pulse = 1'b1; mask_wr_en = 1'b1; mask_wr_data = onebit(51); tick();
        chk(status_o[51] === 1'b1, "R10 event beats clear", 64'(status_o[51]), 64'd1);
        chk(mask_o === onebit(51), "R10 mask takes written value", mask_o, onebit(51));
        mwr(onebit(51));
        chk(status_o[51] === 1'b0, "R10 clear by mask write", 64'(status_o[51]), 64'd0);
        mwr('0);
        aux_err_pulse[8] = 1'b1; tick();
        repeat (3) tick();
        chk(status_o[63] === 1'b1, "R10 sticky bit holds", 64'(status_o[63]), 64'd1);

        // R11: reset mid-run
        rst_n = 1'b0;
        mwr(onebit(60));
        tick();
        chk(status_o === '0 && mask_o === '0 && irq_o === 1'b0, "R11 reset clears all",
            status_o, '0);
        rst_n = 1'b1;
        tick(); tick();

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule